// File: doc/BRIEF.md
# Ethernet PHY Loopback Path Selector

This block steers data between the MAC-facing side of a 10/100 physical-layer device and its line-facing symbol interface. In normal operation, MAC transmit data passes through a fixed-latency pipeline to the line transmitter. That pipeline stands in for the coding stages. Data received from the line goes back to the MAC after one register.

Two configuration bits select one of two test paths. Near-end loopback turns MAC transmit data around after the coding pipeline and returns it on the MAC receive outputs, and it keeps the line transmitter silent. Far loopback echoes line receive data straight back onto the line transmitter, and it cuts the MAC off in both directions. The selected mode is latched only while the whole path is idle, so a mode change never truncates a frame.

Top module: `eth_loop_sel`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero after that edge and the active mode returns to normal.
- R2: In normal mode, `line_txd` and `line_tx_en` reproduce `mac_txd` and `mac_tx_en` exactly PIPE_DEPTH rising edges after the edge that sampled them.
- R3: In normal mode, `mac_rxd` and `mac_rx_dv` reproduce `line_rxd` and `line_rx_dv` one rising edge after the edge that sampled them.
- R4: In near-end mode (`cfg_near_lb`=1), `mac_rxd` and `mac_rx_dv` reproduce `mac_txd` and `mac_tx_en` after PIPE_DEPTH rising edges, and `line_rxd` and `line_rx_dv` have no effect on them.
- R5: In near-end mode, `line_tx_en` and `line_txd` stay zero, whatever the value of `mac_tx_en`.
- R6: In far mode (`cfg_far_lb`=1, `cfg_near_lb`=0), `line_txd` and `line_tx_en` reproduce `line_rxd` and `line_rx_dv` one rising edge later, and `mac_txd` and `mac_tx_en` have no effect on them.
- R7: In far mode, `mac_rxd` and `mac_rx_dv` are held at zero.
- R8: When both configuration bits are 1, near-end mode is selected.
- R9: The configuration bits are adopted only at a rising edge where `mac_tx_en` is 0, `line_rx_dv` is 0, and no valid data remains in the coding pipeline. In every other cycle, the previous mode remains in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_near_lb | input | 1 | Request for near-end loopback |
| cfg_far_lb | input | 1 | Request for far loopback |
| mac_txd | input | DATA_W | Transmit data from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_rxd | output | DATA_W | Receive data to the MAC |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| line_txd | output | DATA_W | Transmit symbols to the line driver |
| line_tx_en | output | 1 | Line transmitter enable |
| line_rxd | input | DATA_W | Receive symbols from the line |
| line_rx_dv | input | 1 | Line receive valid |

## Verification
Each mode is driven with independent random traffic on the MAC transmit side and on the line receive side at the same time. Because both sides are active together, any leak from the isolated side, and any swap between the short path and the pipeline path, shows up at once. A run with both configuration bits set separates the priority rule from plain near-end selection. Directed cases request a mode change in the middle of a MAC burst and in the middle of a line burst. They then confirm that the old routing holds until the path drains, and that the new routing takes over afterwards.

// File: rtl/eth_lb_pkg.sv
package eth_lb_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL = 2'd0,
    LB_NEAR   = 2'd1,
    LB_FAR    = 2'd2
  } lb_mode_e;
endpackage

// File: rtl/eth_lb_mode_ctl.sv
module eth_lb_mode_ctl
  import eth_lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_near,
  input  logic     cfg_far,
  input  logic     mac_tx_en,
  input  logic     pipe_busy,
  input  logic     line_rx_dv,
  output lb_mode_e mode_q
);
  logic     path_idle;
  lb_mode_e mode_req;

  always_comb begin
    path_idle = !mac_tx_en && !pipe_busy && !line_rx_dv;
    if (cfg_near)     mode_req = LB_NEAR;
    else if (cfg_far) mode_req = LB_FAR;
    else              mode_req = LB_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= LB_NORMAL;
    else if (path_idle) mode_q <= mode_req;
  end
endmodule

// File: rtl/eth_lb_txpipe.sv
module eth_lb_txpipe #(
  parameter int DATA_W     = 4,
  parameter int PIPE_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_d,
  input  logic              in_en,
  output logic [DATA_W-1:0] tap_d,
  output logic              tap_en,
  output logic              busy
);
  localparam int STAGES = PIPE_DEPTH - 1;
  localparam int ENT_W  = DATA_W + 1;

  generate
    if (STAGES == 0) begin : g_bypass
      assign tap_d  = in_d;
      assign tap_en = in_en;
      assign busy   = 1'b0;
    end else begin : g_stages
      logic [ENT_W-1:0] stg [STAGES];
      logic             any_v;

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= {in_en, in_d};
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end

      always_comb begin
        any_v = 1'b0;
        for (int i = 0; i < STAGES; i++) any_v = any_v | stg[i][DATA_W];
      end

      assign tap_d  = stg[STAGES-1][DATA_W-1:0];
      assign tap_en = stg[STAGES-1][DATA_W];
      assign busy   = any_v;
    end
  endgenerate
endmodule

// File: rtl/eth_lb_outmux.sv
module eth_lb_outmux
  import eth_lb_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  lb_mode_e          mode,
  input  logic [DATA_W-1:0] tap_d,
  input  logic              tap_en,
  input  logic [DATA_W-1:0] line_rxd,
  input  logic              line_rx_dv,
  output logic [DATA_W-1:0] mac_rxd,
  output logic              mac_rx_dv,
  output logic [DATA_W-1:0] line_txd,
  output logic              line_tx_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mac_rxd    <= '0;
      mac_rx_dv  <= 1'b0;
      line_txd   <= '0;
      line_tx_en <= 1'b0;
    end else begin
      case (mode)
        LB_NEAR: begin
          mac_rxd    <= tap_d;
          mac_rx_dv  <= tap_en;
          line_txd   <= '0;
          line_tx_en <= 1'b0;
        end
        LB_FAR: begin
          mac_rxd    <= '0;
          mac_rx_dv  <= 1'b0;
          line_txd   <= line_rxd;
          line_tx_en <= line_rx_dv;
        end
        default: begin
          mac_rxd    <= line_rxd;
          mac_rx_dv  <= line_rx_dv;
          line_txd   <= tap_d;
          line_tx_en <= tap_en;
        end
      endcase
    end
  end
endmodule

// File: rtl/eth_loop_sel.sv
module eth_loop_sel
  import eth_lb_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int PIPE_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_near_lb,
  input  logic              cfg_far_lb,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  output logic [DATA_W-1:0] mac_rxd,
  output logic              mac_rx_dv,
  output logic [DATA_W-1:0] line_txd,
  output logic              line_tx_en,
  input  logic [DATA_W-1:0] line_rxd,
  input  logic              line_rx_dv
);
  logic [DATA_W-1:0] tap_d;
  logic              tap_en;
  logic              pipe_busy;
  lb_mode_e          mode_q;

  eth_lb_mode_ctl u_mode (
    .clk        (clk),
    .rst        (rst),
    .cfg_near   (cfg_near_lb),
    .cfg_far    (cfg_far_lb),
    .mac_tx_en  (mac_tx_en),
    .pipe_busy  (pipe_busy),
    .line_rx_dv (line_rx_dv),
    .mode_q     (mode_q)
  );

  eth_lb_txpipe #(.DATA_W(DATA_W), .PIPE_DEPTH(PIPE_DEPTH)) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .in_d   (mac_txd),
    .in_en  (mac_tx_en),
    .tap_d  (tap_d),
    .tap_en (tap_en),
    .busy   (pipe_busy)
  );

  eth_lb_outmux #(.DATA_W(DATA_W)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_q),
    .tap_d      (tap_d),
    .tap_en     (tap_en),
    .line_rxd   (line_rxd),
    .line_rx_dv (line_rx_dv),
    .mac_rxd    (mac_rxd),
    .mac_rx_dv  (mac_rx_dv),
    .line_txd   (line_txd),
    .line_tx_en (line_tx_en)
  );
endmodule

// File: rtl/eth_loop_sel_chk.sv
module eth_loop_sel_chk
  import eth_lb_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mac_tx_en,
  input logic [DATA_W-1:0] mac_rxd,
  input logic              mac_rx_dv,
  input logic [DATA_W-1:0] line_txd,
  input logic              line_tx_en,
  input logic [DATA_W-1:0] line_rxd,
  input logic              line_rx_dv,
  input lb_mode_e          mode_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mac_rxd == '0 && !mac_rx_dv && line_txd == '0 && !line_tx_en && mode_q == LB_NORMAL));

  // R3
  normal_rx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_NORMAL) |=> (mac_rx_dv == $past(line_rx_dv) && mac_rxd == $past(line_rxd)));

  // R5
  near_tx_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_NEAR) |=> (!line_tx_en && line_txd == '0));

  // R6
  far_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_FAR) |=> (line_tx_en == $past(line_rx_dv) && line_txd == $past(line_rxd)));

  // R7
  far_mac_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_FAR) |=> (!mac_rx_dv && mac_rxd == '0));

  // R9
  mode_hold_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_tx_en || line_rx_dv) |=> $stable(mode_q));
endmodule

bind eth_loop_sel eth_loop_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mac_tx_en  (mac_tx_en),
  .mac_rxd    (mac_rxd),
  .mac_rx_dv  (mac_rx_dv),
  .line_txd   (line_txd),
  .line_tx_en (line_tx_en),
  .line_rxd   (line_rxd),
  .line_rx_dv (line_rx_dv),
  .mode_q     (mode_q)
);

// File: tb/eth_loop_sel_tb.sv
module eth_loop_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 4;
  localparam int PIPE       = 3;
  localparam int M_NORMAL   = 0;
  localparam int M_NEAR     = 1;
  localparam int M_FAR      = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_near_lb = 1'b0, cfg_far_lb = 1'b0;
  logic [DW-1:0] mac_txd = '0, line_rxd = '0;
  logic          mac_tx_en = 1'b0, line_rx_dv = 1'b0;
  logic [DW-1:0] mac_rxd, line_txd;
  logic          mac_rx_dv, line_tx_en;

  int errors = 0;
  int checks = 0;
  int edge_n = 16;
  int model  = M_NORMAL;
  bit done   = 1'b0;

  logic          h_txen [16];
  logic [DW-1:0] h_txd  [16];
  logic          h_rxdv [16];
  logic [DW-1:0] h_rxd  [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_loop_sel #(.DATA_W(DW), .PIPE_DEPTH(PIPE)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_near_lb(cfg_near_lb), .cfg_far_lb(cfg_far_lb),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv),
    .line_txd(line_txd), .line_tx_en(line_tx_en),
    .line_rxd(line_rxd), .line_rx_dv(line_rx_dv)
  );

  task automatic cmp(input string req, input string sig, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", req, sig, act, exp, edge_n);
    end
  endtask

  task automatic check_outputs(input string tag);
    int ph = (edge_n - PIPE + 1) % 16;
    int pc = edge_n % 16;
    logic [DW:0] e_line, e_mac;
    string rl, rm;
    case (model)
      M_NEAR: begin
        e_line = '0;
        e_mac  = {h_txen[ph], h_txd[ph]};
        rl = "R5"; rm = "R4";
      end
      M_FAR: begin
        e_line = {h_rxdv[pc], h_rxd[pc]};
        e_mac  = '0;
        rl = "R6"; rm = "R7";
      end
      default: begin
        e_line = {h_txen[ph], h_txd[ph]};
        e_mac  = {h_rxdv[pc], h_rxd[pc]};
        rl = "R2"; rm = "R3";
      end
    endcase
    if (tag != "") begin
      rl = tag; rm = tag;
    end
    cmp(rl, "line_tx", {line_tx_en, line_txd}, e_line);
    cmp(rm, "mac_rx", {mac_rx_dv, mac_rxd}, e_mac);
  endtask

  task automatic cyc(input logic en, input logic [DW-1:0] d,
                     input logic rdv, input logic [DW-1:0] rd, input string tag);
    mac_tx_en  = en;  mac_txd  = d;
    line_rx_dv = rdv; line_rxd = rd;
    h_txen[edge_n % 16] = en;  h_txd[edge_n % 16] = d;
    h_rxdv[edge_n % 16] = rdv; h_rxd[edge_n % 16] = rd;
    @(negedge clk);
    check_outputs(tag);
    edge_n++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, "");
  endtask

  task automatic set_mode(input logic nr, input logic fr, input int m);
    idle(PIPE + 2);
    cfg_near_lb = nr;
    cfg_far_lb  = fr;
    idle(2);
    model = m;
  endtask

  task automatic random_traffic(input int n, input string tag);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 4) != 0, DW'($urandom), ($urandom % 3) != 0, DW'($urandom), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    for (int i = 0; i < 16; i++) begin
      h_txen[i] = 1'b0; h_txd[i] = '0; h_rxdv[i] = 1'b0; h_rxd[i] = '0;
    end
    // R1: drive activity and config during reset; outputs must stay clear
    cfg_near_lb = 1'b1;
    mac_tx_en = 1'b1; mac_txd = 4'hA; line_rx_dv = 1'b1; line_rxd = 4'h5;
    repeat (5) @(negedge clk);
    cmp("R1", "line_tx", {line_tx_en, line_txd}, '0);
    cmp("R1", "mac_rx", {mac_rx_dv, mac_rxd}, '0);
    cfg_near_lb = 1'b0;
    mac_tx_en = 1'b0; mac_txd = '0; line_rx_dv = 1'b0; line_rxd = '0;
    @(negedge clk);
    rst = 1'b0;
    // R1: first traffic after reset must follow normal routing
    cyc(1'b1, 4'h3, 1'b1, 4'hC, "R1");
    idle(PIPE + 1);

    // R2 / R3: normal mode, both directions busy together
    random_traffic(300, "");

    // R4 / R5: near-end loopback with line traffic that must be ignored
    set_mode(1'b1, 1'b0, M_NEAR);
    random_traffic(300, "");

    // R6 / R7: far loopback with MAC traffic that must be ignored
    set_mode(1'b0, 1'b1, M_FAR);
    random_traffic(300, "");

    // R8: both bits set selects near-end
    set_mode(1'b1, 1'b1, M_NEAR);
    random_traffic(200, "R8");

    // R9: request far in the middle of a MAC burst in normal mode
    set_mode(1'b0, 1'b0, M_NORMAL);
    cyc(1'b1, 4'h1, 1'b0, '0, "R9");
    cyc(1'b1, 4'h2, 1'b0, '0, "R9");
    cfg_far_lb = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b1, DW'(i + 4), 1'b0, '0, "R9");
    idle(PIPE + 2);
    model = M_FAR;
    for (int i = 0; i < 6; i++) cyc(1'b1, 4'hF, 1'b1, DW'(i + 7), "R9");

    // R9: request normal while a line burst is echoing in far mode
    cfg_far_lb = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b1, DW'(i + 2), "R9");
    cyc(1'b0, '0, 1'b0, '0, "R9");
    model = M_NORMAL;
    idle(PIPE);
    for (int i = 0; i < 6; i++) cyc(1'b1, DW'(i + 9), 1'b1, DW'(15 - i), "R9");
    idle(PIPE + 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule